// File: doc/BRIEF.md
# Four-Channel Power Rail Sequencer

This block brings four supply rails up and down in an order chosen by software-loaded delay values. Turn-on waits until an active-low enable is asserted and every rail's undervoltage comparator reports good. Both conditions must then hold without a break for a lockout interval. After the lockout, one on-delay counter per channel starts, all in the same cycle. Each rail's enable rises when its own counter expires, so the rails come up in the order their delays set.

Once every rail enable is set and every rail reports that it has ramped, a settling interval runs. After it, the active-low system reset output is released high. Deasserting the enable pulls that reset low at once and starts the per-channel off-delay counters together, with no lockout. A rail that has turned off stays off until the next turn-on.

Any undervoltage report drops every rail in the next cycle. If the enable is asserted again part-way through a turn-off, the turn-off is abandoned and a new turn-on begins.

Top module: `rail_sequencer`

## Requirements
- R1: While reset is asserted, every rail enable is low, `hold_rst_n` is low and `seq_state` reads IDLE. The state codes are IDLE=0, LOCKOUT=1, RAMP_UP=2, SETTLE=3, ON=4, RAMP_DOWN=5.
- R2: The block leaves IDLE, to LOCKOUT, only in a cycle where `en_n` is low and all four `uv_ok` bits are high. Otherwise it stays in IDLE.
- R3: With the start conditions held, LOCKOUT lasts exactly `LOCK_TICKS` cycles and is then followed by RAMP_UP. If `en_n` rises during LOCKOUT, the block returns to IDLE when no rail is on. A later entry into LOCKOUT counts the full interval again.
- R4: Rail i's enable rises at the clock edge that ends its (on-delay[i]+1)-th RAMP_UP cycle, so a zero delay turns the rail on at the first edge. Rails with equal delays rise in the same cycle. No rail enable rises in any other state.
- R5: RAMP_UP moves to SETTLE in the first cycle in which all four enables and all four `rail_up` bits are high. `rail_up` has no effect while any enable is still low. SETTLE lasts exactly `SETTLE_TICKS` cycles, then the state becomes ON.
- R6: `hold_rst_n` is high exactly while the state is ON, and it rises only on leaving SETTLE.
- R7: With no undervoltage, `en_n` high in RAMP_UP, SETTLE or ON moves the block to RAMP_DOWN at the next edge and drives `hold_rst_n` low. No further rail turns on at that edge.
- R8: A rail that is on when RAMP_DOWN is entered drops its enable at the edge that ends its (off-delay[i]+1)-th RAMP_DOWN cycle, and it stays off. One cycle after the last rail drops, the state returns to IDLE.
- R9: Any `uv_ok` bit low in any state other than IDLE clears all four enables and forces IDLE at the next edge. This takes priority over an `en_n` change in the same cycle.
- R10: `en_n` low again during RAMP_DOWN, with no undervoltage, moves the block to LOCKOUT at the next edge. Rails that are still on stay on. After the lockout a full RAMP_UP runs and turns the remaining rails on with their on-delays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n | input | 1 | Active-low sequence enable |
| uv_ok | input | NCH | Per-rail undervoltage comparator, 1 = above threshold |
| rail_up | input | NCH | Per-rail ramp-complete status, 1 = fully on |
| on_dly | input | NCH*CNT_W | Per-channel on-delay in ticks, channel i at bits [i*CNT_W +: CNT_W] |
| off_dly | input | NCH*CNT_W | Per-channel off-delay in ticks, same packing |
| rail_en | output | NCH | Per-rail enable to the external switch |
| hold_rst_n | output | 1 | Active-low system reset, high once rails have settled |
| seq_state | output | 3 | Sequencer state code (see R1) |

## Verification
Two events can collide in one cycle. The first is an undervoltage report arriving together with `en_n` rising while the block is ON. The bench drives both on the same negative edge. It then expects IDLE with every rail cleared, not RAMP_DOWN, because the fault path has priority. The second collision is several on-delay counters expiring together, from equal or zero delays. It is judged by requiring the matching enables to rise in the same cycle and SETTLE to start one cycle after the last one rises. A disable that lands while rails are still coming up is also checked: no pending rail may turn on at that edge.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE     = 3'd0,
    SQ_LOCK     = 3'd1,
    SQ_RAMP_UP  = 3'd2,
    SQ_SETTLE   = 3'd3,
    SQ_ON       = 3'd4,
    SQ_RAMP_DN  = 3'd5
  } seq_state_e;

  // An interval has elapsed once the running count has reached its limit.
  function automatic logic interval_done(input logic [63:0] count,
                                         input logic [63:0] limit);
    return count >= limit;
  endfunction

  // Saturating-free step: the caller clears on expiry, so no wrap occurs.
  function automatic logic [63:0] step_count(input logic [63:0] count,
                                             input logic        run,
                                             input logic        expired);
    if (!run || expired) return 64'd0;
    return count + 64'd1;
  endfunction

endpackage

// File: rtl/rail_seq_timer.sv
module rail_seq_timer
  import rail_seq_pkg::*;
#(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

  logic [W-1:0]  cnt_q;
  logic [63:0]   cnt_next;

  assign done     = run && interval_done(64'(cnt_q), 64'(LIMIT - 1));
  assign cnt_next = step_count(64'(cnt_q), run, done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next[W-1:0];
  end
endmodule

// File: rtl/rail_seq_chan.sv
module rail_seq_chan
  import rail_seq_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             on_run,
  input  logic             off_run,
  input  logic [CNT_W-1:0] on_limit,
  input  logic [CNT_W-1:0] off_limit,
  output logic             on_fire,
  output logic             off_fire
);
  logic [CNT_W-1:0] on_cnt_q, off_cnt_q;
  logic [63:0]      on_next, off_next;

  assign on_fire  = on_run  && interval_done(64'(on_cnt_q),  64'(on_limit));
  assign off_fire = off_run && interval_done(64'(off_cnt_q), 64'(off_limit));
  assign on_next  = step_count(64'(on_cnt_q),  on_run,  on_fire);
  assign off_next = step_count(64'(off_cnt_q), off_run, off_fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_cnt_q  <= '0;
      off_cnt_q <= '0;
    end else begin
      on_cnt_q  <= on_next[CNT_W-1:0];
      off_cnt_q <= off_next[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import rail_seq_pkg::*;
#(
  parameter int NCH          = 4,
  parameter int CNT_W        = 32,
  parameter int LOCK_TICKS   = 1000000,
  parameter int SETTLE_TICKS = 16000000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_n,
  input  logic [NCH-1:0]       uv_ok,
  input  logic [NCH-1:0]       rail_up,
  input  logic [NCH*CNT_W-1:0] on_dly,
  input  logic [NCH*CNT_W-1:0] off_dly,
  output logic [NCH-1:0]       rail_en,
  output logic                 hold_rst_n,
  output logic [2:0]           seq_state
);
  seq_state_e     state_q, state_d;
  logic [NCH-1:0] rail_en_d;

  // Named internal events, also observed by the bound checker.
  logic           all_uv_good;
  logic           fault_evt;
  logic           start_ok;
  logic           disable_evt;
  logic           all_up_evt;
  logic           lock_done;
  logic           settle_done;
  logic [NCH-1:0] on_fire, off_fire;
  logic [NCH-1:0] on_run, off_run;

  assign all_uv_good = &uv_ok;
  assign fault_evt   = !all_uv_good;
  assign start_ok    = !en_n && all_uv_good;
  assign disable_evt = en_n && all_uv_good;
  assign all_up_evt  = (&rail_en) && (&rail_up);

  rail_seq_timer #(.LIMIT(LOCK_TICKS)) u_lock_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   ((state_q == SQ_LOCK) && start_ok),
    .done  (lock_done)
  );

  rail_seq_timer #(.LIMIT(SETTLE_TICKS)) u_settle_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   ((state_q == SQ_SETTLE) && start_ok),
    .done  (settle_done)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    assign on_run[i]  = (state_q == SQ_RAMP_UP) && !rail_en[i];
    assign off_run[i] = (state_q == SQ_RAMP_DN) && rail_en[i];

    rail_seq_chan #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .on_run    (on_run[i]),
      .off_run   (off_run[i]),
      .on_limit  (on_dly[i*CNT_W +: CNT_W]),
      .off_limit (off_dly[i*CNT_W +: CNT_W]),
      .on_fire   (on_fire[i]),
      .off_fire  (off_fire[i])
    );
  end

  // Rail enable update: fault clears all, otherwise only the active ramp edits.
  always_comb begin
    rail_en_d = rail_en;
    if (fault_evt)
      rail_en_d = '0;
    else if (state_q == SQ_RAMP_UP && !en_n)
      rail_en_d = rail_en | on_fire;
    else if (state_q == SQ_RAMP_DN && en_n)
      rail_en_d = rail_en & ~off_fire;
  end

  always_comb begin
    state_d = state_q;
    if (fault_evt && state_q != SQ_IDLE) begin
      state_d = SQ_IDLE;
    end else begin
      unique case (state_q)
        SQ_IDLE:    if (start_ok) state_d = SQ_LOCK;
        SQ_LOCK: begin
          if (en_n)           state_d = (|rail_en) ? SQ_RAMP_DN : SQ_IDLE;
          else if (lock_done) state_d = SQ_RAMP_UP;
        end
        SQ_RAMP_UP: begin
          if (disable_evt)     state_d = SQ_RAMP_DN;
          else if (all_up_evt) state_d = SQ_SETTLE;
        end
        SQ_SETTLE: begin
          if (disable_evt)      state_d = SQ_RAMP_DN;
          else if (settle_done) state_d = SQ_ON;
        end
        SQ_ON:      if (disable_evt) state_d = SQ_RAMP_DN;
        SQ_RAMP_DN: begin
          if (start_ok)         state_d = SQ_LOCK;
          else if (rail_en == '0) state_d = SQ_IDLE;
        end
        default:    state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      rail_en <= '0;
    end else begin
      state_q <= state_d;
      rail_en <= rail_en_d;
    end
  end

  assign hold_rst_n = (state_q == SQ_ON);
  assign seq_state  = state_q;

endmodule

// File: rtl/rail_sequencer_chk.sv
module rail_sequencer_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en_n,
  input logic [NCH-1:0] uv_ok,
  input logic [NCH-1:0] rail_en,
  input logic           hold_rst_n,
  input logic [2:0]     seq_state,
  input logic [NCH-1:0] on_fire,
  input logic           lock_done,
  input logic           settle_done
);
  logic uv_all;
  assign uv_all = &uv_ok;

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd0 && !(!en_n && uv_all)) |=> seq_state == 3'd0);

  p_lock_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_done |=> seq_state == 3'd2);

  p_on_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|on_fire) && !en_n && uv_all) |=> ((rail_en & $past(on_fire)) == $past(on_fire)));

  p_rise_only_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state != 3'd2) |=> ((rail_en & ~$past(rail_en)) == '0));

  p_settle_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_done && !en_n && uv_all) |=> seq_state == 3'd4);

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_rst_n) |-> $past(seq_state) == 3'd3);

  p_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((seq_state inside {3'd2, 3'd3, 3'd4}) && en_n && uv_all)
      |=> (seq_state == 3'd5 && !hold_rst_n));

  p_fall_only_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state != 3'd5 && uv_all) |=> ((~rail_en & $past(rail_en)) == '0));

  p_fault_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state != 3'd0 && !uv_all) |=> (rail_en == '0 && seq_state == 3'd0));

  p_reenable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd5 && !en_n && uv_all)
      |=> (seq_state == 3'd1 && rail_en == $past(rail_en)));

endmodule

bind rail_sequencer rail_sequencer_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_n        (en_n),
  .uv_ok       (uv_ok),
  .rail_en     (rail_en),
  .hold_rst_n  (hold_rst_n),
  .seq_state   (seq_state),
  .on_fire     (on_fire),
  .lock_done   (lock_done),
  .settle_done (settle_done)
);

// File: tb/rail_sequencer_tb.sv
module rail_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;
  localparam int CW         = 32;
  localparam int LOCK       = 8;
  localparam int SETL       = 12;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            en_n = 1;
  logic [3:0]      uv_ok = 4'hF;
  logic [3:0]      rail_up = 4'h0;
  logic [NCH*CW-1:0] on_dly, off_dly;
  logic [3:0]      rail_en;
  logic            hold_rst_n;
  logic [2:0]      seq_state;

  int on_d[4];
  int off_d[4];
  logic       follow_up = 1;
  logic [3:0] force_up  = 4'h0;

  int checks = 0;
  int errs   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      on_dly[i*CW +: CW]  = 32'(on_d[i]);
      off_dly[i*CW +: CW] = 32'(off_d[i]);
    end
  end

  always @(negedge clk) rail_up <= follow_up ? rail_en : force_up;

  rail_sequencer #(.NCH(NCH), .CNT_W(CW), .LOCK_TICKS(LOCK), .SETTLE_TICKS(SETL)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .uv_ok(uv_ok), .rail_up(rail_up),
    .on_dly(on_dly), .off_dly(off_dly), .rail_en(rail_en),
    .hold_rst_n(hold_rst_n), .seq_state(seq_state)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: one elapsed-cycle count per state visit.
  int         m_state = 0;
  logic [3:0] m_en = 0;
  int         phase = 0;
  int         m_nxt;
  logic [3:0] m_en_nx;
  logic       m_flt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_en = 0; phase = 0;
    end else begin
      m_flt = (uv_ok != 4'hF);
      m_nxt = m_state; m_en_nx = m_en;
      if (m_flt && m_state != 0) begin
        m_nxt = 0; m_en_nx = 0;
      end else if (m_flt) begin
        m_en_nx = 0;
      end else begin
        case (m_state)
          0: if (!en_n) m_nxt = 1;
          1: if (en_n) m_nxt = (m_en != 0) ? 5 : 0;
             else if (phase >= LOCK - 1) m_nxt = 2;
          2: if (en_n) m_nxt = 5;
             else begin
               for (int i = 0; i < 4; i++)
                 if (!m_en[i] && phase >= on_d[i]) m_en_nx[i] = 1;
               if (m_en == 4'hF && rail_up == 4'hF) m_nxt = 3;
             end
          3: if (en_n) m_nxt = 5; else if (phase >= SETL - 1) m_nxt = 4;
          4: if (en_n) m_nxt = 5;
          5: if (!en_n) m_nxt = 1;
             else begin
               if (m_en == 0) m_nxt = 0;
               for (int i = 0; i < 4; i++)
                 if (m_en[i] && phase >= off_d[i]) m_en_nx[i] = 0;
             end
          default: m_nxt = 0;
        endcase
      end
      phase   = (m_nxt != m_state) ? 0 : phase + 1;
      m_state = m_nxt;
      m_en    = m_en_nx;
    end
  end

  // Per-cycle comparison and event timestamps.
  int cyc = 0;
  int t_enter[6];
  int t_rise[4];
  int t_fall[4];
  logic [2:0] prev_st = 0;
  logic [3:0] prev_en = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R4", "model rail_en", longint'(rail_en), longint'(m_en));
      chk("R6", "model hold_rst_n", longint'(hold_rst_n), longint'(m_state == 4));
      chk("R3", "model seq_state", longint'(seq_state), longint'(m_state));
    end
    if (seq_state != prev_st) t_enter[seq_state] = cyc;
    for (int i = 0; i < 4; i++) begin
      if (rail_en[i] && !prev_en[i]) t_rise[i] = cyc;
      if (!rail_en[i] && prev_en[i]) t_fall[i] = cyc;
    end
    prev_st = seq_state;
    prev_en = rail_en;
  end

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wait_st(input int s, input int lim);
    int n = 0;
    while (seq_state != 3'(s) && n < lim) begin tick(1); n++; end
  endtask

  initial begin
    on_d  = '{5, 0, 9, 3};
    off_d = '{2, 7, 0, 4};
    tick(2);
    chk("R1", "reset rail_en", rail_en, 0);
    chk("R1", "reset hold_rst_n", hold_rst_n, 0);
    chk("R1", "reset state", seq_state, 0);
    rst_n = 1;
    tick(3);
    chk("R2", "idle with en_n high", seq_state, 0);
    uv_ok = 4'b1011; en_n = 0;
    tick(3);
    chk("R2", "idle with uv low", seq_state, 0);
    uv_ok = 4'hF;
    wait_st(2, 100);
    chk("R3", "lockout length", t_enter[2] - t_enter[1], LOCK);
    wait_st(4, 200);
    for (int i = 0; i < 4; i++)
      chk("R4", $sformatf("on delay ch%0d", i), t_rise[i] - t_enter[2], on_d[i] + 1);
    chk("R5", "settle entry", t_enter[3] - t_enter[2], 11);
    chk("R5", "settle length", t_enter[4] - t_enter[3], SETL);
    chk("R6", "released in ON", hold_rst_n, 1);

    en_n = 1;
    tick(1);
    chk("R7", "ramp down entered", seq_state, 5);
    chk("R7", "reset low at once", hold_rst_n, 0);
    wait_st(0, 100);
    for (int i = 0; i < 4; i++)
      chk("R8", $sformatf("off delay ch%0d", i), t_fall[i] - t_enter[5], off_d[i] + 1);
    chk("R8", "idle after last off", t_enter[0] - t_enter[5], 9);

    // Lockout interrupted by enable.
    en_n = 0; tick(4);
    chk("R3", "in lockout", seq_state, 1);
    en_n = 1; tick(1);
    chk("R3", "lockout abandoned", seq_state, 0);
    en_n = 0;
    wait_st(2, 100);
    chk("R3", "lockout restarted", t_enter[2] - t_enter[1], LOCK);
    wait_st(4, 200);
    uv_ok = 4'b1101; tick(1);
    chk("R9", "fault clears rails", rail_en, 0);
    chk("R9", "fault to idle", seq_state, 0);
    uv_ok = 4'hF;

    // Fault and disable in the same cycle.
    wait_st(4, 300);
    en_n = 1; uv_ok = 4'b0111; tick(1);
    chk("R9", "fault beats disable state", seq_state, 0);
    chk("R9", "fault beats disable rails", rail_en, 0);
    uv_ok = 4'hF; tick(2);

    // rail_up held low after all enables set.
    follow_up = 0; force_up = 4'h0; en_n = 0;
    wait_st(2, 100);
    tick(20);
    chk("R5", "waits for rail_up", seq_state, 2);
    chk("R5", "all enables set", rail_en, 15);
    force_up = 4'hF; tick(2);
    chk("R5", "settle after rail_up", seq_state, 3);
    wait_st(4, 100);

    // Re-enable during ramp down.
    off_d = '{20, 20, 3, 20};
    en_n = 1; tick(6);
    chk("R8", "partial ramp down", rail_en, 4'b1011);
    en_n = 0; tick(1);
    chk("R10", "back to lockout", seq_state, 1);
    chk("R10", "rails kept", rail_en, 4'b1011);
    wait_st(2, 100);
    wait_st(4, 200);
    chk("R10", "all on again", rail_en, 15);
    chk("R10", "ch2 on delay", t_rise[2] - t_enter[2], on_d[2] + 1);

    // Disable while ramping up.
    en_n = 1; wait_st(0, 200);
    on_d = '{0, 30, 30, 2};
    en_n = 0; wait_st(2, 100); tick(5);
    chk("R4", "partial ramp up", rail_en, 4'b1001);
    en_n = 1; tick(1);
    chk("R7", "ramp up abandoned", seq_state, 5);
    chk("R7", "no new rail", rail_en, 4'b1001);
    wait_st(0, 200);

    // Equal and zero delays, rail_up already high.
    on_d = '{4, 4, 0, 0};
    en_n = 0; wait_st(4, 200);
    chk("R4", "equal delays", t_rise[0], t_rise[1]);
    chk("R4", "zero delay ch2", t_rise[2] - t_enter[2], 1);
    chk("R4", "zero delay ch3", t_rise[3] - t_enter[2], 1);
    chk("R5", "rail_up ignored early", t_enter[3] - t_enter[2], 6);

    // Fault during ramp down.
    en_n = 1; tick(1);
    uv_ok = 4'b1110; tick(1);
    chk("R9", "fault in ramp down", seq_state, 0);
    chk("R9", "fault rails in ramp down", rail_en, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

endmodule